// File: doc/BRIEF.md
# Sector-Synchronised Multilevel PWM Sampler

This block paces the modulator of a four-level pole stage. The stage's three voltage bands are unequal in height, 0.366 : 0.634 : 0.366. A position accumulator advances by `step` on every clock. Each overflow of the accumulator ends one 30-degree sector. A sector counter runs from 0 to 11, so one fundamental cycle holds twelve sectors. Each sector is split into 1, 2 or 4 equal sample intervals. One triangular carrier restarts at the beginning of each interval, so the carrier stays locked to the start of every sector.

The number of sample intervals per sector depends on the operating frequency `freq`. The frequency is given in tenths of a hertz. Low speed uses 4 intervals per sector, the middle range uses 2, and high speed uses 1. At one interval per sector the block switches at twelve times the fundamental. The thresholds have hysteresis, and a new interval count takes effect only at a sector boundary.

Each phase's modulating value is an unsigned number in which full scale equals the whole DC link. The block finds the band that the value falls in. It then scales the value's offset inside that band against the one shared carrier. The result is a registered level code from 0 to 3. Modulating values are captured only at the carrier trough and at the carrier peak.

Top module: `sector_pwm_sampler`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `sector`=0, `rate`=4, `strobe`=0, `carrier`=0, and all level codes 0.
- R2: `sector` moves only when the accumulator overflows. Each move is +1, and 11 is followed by 0.
- R3: A sector set to `rate` N (1, 2 or 4) contains exactly N `strobe` pulses. The first pulse falls on the clock where `sector` changes, so one fundamental cycle contains 12·N pulses.
- R4: `carrier` is 0 on every strobe. It rises to its maximum at mid-interval and then falls. With `step`=4096 and `rate`=4, the four carrier values of an interval are 0, 16384, 32767 and 16383.
- R5: The sample rate is chosen as follows, with F_LO=200 (20 Hz), F_HI=400 (40 Hz) and HYST=10 (1 Hz).
  - `freq` > F_HI+HYST selects 1 sample per sector.
  - `freq` < F_LO−HYST selects 4 samples per sector.
  - Otherwise, rate 4 is kept while `freq` ≤ F_LO+HYST.
  - Otherwise, rate 1 is kept while `freq` ≥ F_HI−HYST.
  - In every other case the rate is 2.
- R6: `rate` changes only on the clock where `sector` changes.
- R7: The band edges are EDGE1=1097 and EDGE2=2999 on a 12-bit scale. A value m below EDGE1 is in band 0, a value below EDGE2 is in band 1, and any other value is in band 2. The level code is the band number, plus 1 when the offset scaled to the carrier range exceeds the carrier. So m=0 always gives 0, m=1097 always gives 1 and m=2999 always gives 2. Values inside a band alternate between that band's two codes.
- R8: Modulating inputs are captured only at a carrier trough or a carrier peak. With `step`=0, a change on a modulating input has no effect on the level codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 16 | Fraction of a sector added per clock (2^16 = one sector) |
| freq | input | 12 | Operating frequency, 0.1 Hz per LSB |
| mod_a | input | 12 | Phase A modulating value (full scale = whole DC link) |
| mod_b | input | 12 | Phase B modulating value |
| mod_c | input | 12 | Phase C modulating value |
| strobe | output | 1 | One-clock pulse at each sampling instant |
| sector | output | 4 | Current 30-degree sector, 0..11 |
| rate | output | 3 | Samples per sector in force: 1, 2 or 4 |
| carrier | output | 15 | Shared triangular carrier |
| lvl_a | output | 2 | Phase A pole level code 0..3 |
| lvl_b | output | 2 | Phase B pole level code 0..3 |
| lvl_c | output | 2 | Phase C pole level code 0..3 |

## Verification
The assertions check the following on every cycle:
- the sector counter stays in range and steps by one;
- a strobe is present at every sector change;
- a rate change happens only on a sector change, and a step from 4 to 2 samples is justified by the frequency above the upper hysteresis edge;
- the captured modulating values stay frozen while the accumulator is stopped.

The bench scenarios show what a single-cycle property cannot:
- the exact number of strobes per sector at each rate;
- the carrier shape within an interval;
- the full hysteresis walk through both thresholds;
- the level codes at the band edges and inside each band.

// File: rtl/sector_pwm_sampler.sv
module sector_pwm_sampler #(
  parameter int POS_W  = 16,
  parameter int FREQ_W = 12,
  parameter int MOD_W  = 12,
  parameter int F_LO   = 200,
  parameter int F_HI   = 400,
  parameter int HYST   = 10,
  parameter int EDGE1  = 1097,
  parameter int EDGE2  = 2999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  step,
  input  logic [FREQ_W-1:0] freq,
  input  logic [MOD_W-1:0]  mod_a,
  input  logic [MOD_W-1:0]  mod_b,
  input  logic [MOD_W-1:0]  mod_c,
  output logic              strobe,
  output logic [3:0]        sector,
  output logic [2:0]        rate,
  output logic [POS_W-2:0]  carrier,
  output logic [1:0]        lvl_a,
  output logic [1:0]        lvl_b,
  output logic [1:0]        lvl_c
);
  localparam int CAR_W = POS_W - 1;
  localparam int PW    = MOD_W + 1 + CAR_W;
  localparam logic [FREQ_W-1:0] LO_UP = FREQ_W'(F_LO + HYST);
  localparam logic [FREQ_W-1:0] LO_DN = FREQ_W'(F_LO - HYST);
  localparam logic [FREQ_W-1:0] HI_UP = FREQ_W'(F_HI + HYST);
  localparam logic [FREQ_W-1:0] HI_DN = FREQ_W'(F_HI - HYST);
  localparam logic [MOD_W-1:0]  E1 = MOD_W'(EDGE1);
  localparam logic [MOD_W-1:0]  E2 = MOD_W'(EDGE2);
  localparam logic [MOD_W:0]    W0 = (MOD_W+1)'(EDGE1);
  localparam logic [MOD_W:0]    W1 = (MOD_W+1)'(EDGE2 - EDGE1);
  localparam logic [MOD_W:0]    W2 = (MOD_W+1)'((1 << MOD_W) - EDGE2);

  logic [POS_W-1:0]          pos_q, pos_n;
  logic                      carry, strobe_n, peak_n;
  logic [2:0]                rate_want;
  logic [2:0][MOD_W-1:0]     m_in, hold_q;
  logic [2:0][1:0]           lvl_q;

  function automatic logic [POS_W-1:0] loc(input logic [POS_W-1:0] p, input logic [2:0] r);
    case (r)
      3'd4:    loc = p << 2;
      3'd2:    loc = p << 1;
      default: loc = p;
    endcase
  endfunction

  function automatic logic [1:0] sidx(input logic [POS_W-1:0] p, input logic [2:0] r);
    case (r)
      3'd4:    sidx = p[POS_W-1 -: 2];
      3'd2:    sidx = {1'b0, p[POS_W-1]};
      default: sidx = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] lvl_of(input logic [MOD_W-1:0] m, input logic [CAR_W-1:0] c);
    logic [MOD_W:0] off, wid;
    logic [1:0]     b;
    logic [PW-1:0]  lhs, rhs;
    if (m < E1) begin
      b = 2'd0; off = {1'b0, m}; wid = W0;
    end else if (m < E2) begin
      b = 2'd1; off = {1'b0, m - E1}; wid = W1;
    end else begin
      b = 2'd2; off = {1'b0, m - E2}; wid = W2;
    end
    lhs = {off, {CAR_W{1'b0}}};
    rhs = PW'(c) * PW'(wid);
    lvl_of = b + {1'b0, lhs > rhs};
  endfunction

  logic [POS_W-1:0] lcl_q, lcl_n;
  assign {carry, pos_n} = {1'b0, pos_q} + {1'b0, step};
  assign lcl_q    = loc(pos_q, rate);
  assign lcl_n    = loc(pos_n, rate);
  assign carrier  = lcl_q[POS_W-1] ? ~lcl_q[POS_W-2:0] : lcl_q[POS_W-2:0];
  assign strobe_n = carry | (sidx(pos_n, rate) != sidx(pos_q, rate));
  assign peak_n   = !carry & lcl_n[POS_W-1] & !lcl_q[POS_W-1];
  assign m_in     = {mod_c, mod_b, mod_a};
  assign {lvl_c, lvl_b, lvl_a} = lvl_q;

  always_comb begin
    if (freq > HI_UP)                      rate_want = 3'd1;
    else if (freq < LO_DN)                 rate_want = 3'd4;
    else if (rate == 3'd4 && freq <= LO_UP) rate_want = 3'd4;
    else if (rate == 3'd1 && freq >= HI_DN) rate_want = 3'd1;
    else                                   rate_want = 3'd2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sector <= '0;
      rate   <= 3'd4;
      strobe <= 1'b0;
      hold_q <= '0;
      lvl_q  <= '0;
    end else begin
      pos_q  <= pos_n;
      strobe <= strobe_n;
      if (carry) begin
        sector <= (sector == 4'd11) ? 4'd0 : sector + 4'd1;
        rate   <= rate_want;
      end
      if (strobe_n | peak_n) hold_q <= m_in;
      for (int i = 0; i < 3; i++) lvl_q[i] <= lvl_of(hold_q[i], carrier);
    end
  end

  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sector < 4'd12); // R2
  AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sector) |-> sector == (($past(sector) == 4'd11) ? 4'd0 : $past(sector) + 4'd1)); // R2
  AST_STROBE_AT_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sector) |-> strobe); // R3
  AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate) |-> !$stable(sector)); // R6
  AST_RATE_HYST: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 3'd2 && $past(rate) == 3'd4) |-> $past(freq) > LO_UP); // R5
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |=> $stable(hold_q)); // R8
endmodule

// File: tb/sector_pwm_sampler_test.sv
module sector_pwm_sampler_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] step = 16'd4096;
  logic [11:0] freq = 12'd100, mod_a = 0, mod_b = 0, mod_c = 0;
  logic strobe; logic [3:0] sector; logic [2:0] rate; logic [14:0] carrier;
  logic [1:0] lvl_a, lvl_b, lvl_c;

  sector_pwm_sampler uut (.clk(clk), .rst_n(rst_n), .step(step), .freq(freq),
    .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c), .strobe(strobe), .sector(sector),
    .rate(rate), .carrier(carrier), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c));

  always #10 clk = ~clk;

  localparam int NV = 9;
  localparam int VF [NV] = '{150, 205, 215, 195, 185, 450, 395, 385, 100};
  localparam int VR [NV] = '{4,   4,   2,   2,   4,   1,   1,   2,   4};

  int n_chk = 0, n_fail = 0;
  int prev_sec = 0, prev_rate = 4, off_bnd = 0, step_bad = 0, wraps = 0;
  int cnt = 0, cnt_rate = 0, cnt_bad = 0, last_cnt = 0, trough_bad = 0;
  bit cnt_valid = 0, sec_chg = 0;
  logic [3:0] seen_a, seen_b, seen_c;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    sec_chg = (int'(sector) != prev_sec);
    if (int'(rate) != prev_rate && !sec_chg) off_bnd++;
    if (sec_chg) begin
      if (int'(sector) != ((prev_sec == 11) ? 0 : prev_sec + 1)) step_bad++;
      if (sector == 0) wraps++;
      if (cnt_valid && cnt != cnt_rate) cnt_bad++;
      last_cnt = cnt; cnt = 0; cnt_rate = int'(rate); cnt_valid = 1;
    end
    if (strobe) begin
      cnt++;
      if (carrier != 0) trough_bad++;
    end
    prev_sec = int'(sector); prev_rate = int'(rate);
  endtask

  task automatic wait_sectors(input int n);
    int k = 0;
    while (k < n) begin
      tick();
      if (sec_chg) k++;
    end
  endtask

  task automatic observe(input int n);
    seen_a = 0; seen_b = 0; seen_c = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      seen_a[lvl_a] = 1'b1; seen_b[lvl_b] = 1'b1; seen_c[lvl_c] = 1'b1;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sector == 0, "R1 sector", sector, 0);
    chk(rate == 4, "R1 rate", rate, 4);
    chk(strobe == 0, "R1 strobe", strobe, 0);
    chk(carrier == 0, "R1 carrier", carrier, 0);
    chk({lvl_a, lvl_b, lvl_c} == 0, "R1 levels", {lvl_a, lvl_b, lvl_c}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      freq = 12'(VF[i]);
      wait_sectors(2);
      chk(int'(rate) == VR[i], $sformatf("R5 freq=%0d rate", VF[i]), rate, VR[i]);
    end

    wait_sectors(13);
    chk(last_cnt == 4, "R3 strobes per sector at rate 4", last_cnt, 4);
    // R4 carrier shape right after a sector start at rate 4
    wait_sectors(1);
    chk(carrier == 0, "R4 carrier at trough", carrier, 0);
    tick(); chk(carrier == 16384, "R4 carrier rising", carrier, 16384);
    tick(); chk(carrier == 32767, "R4 carrier peak", carrier, 32767);
    tick(); chk(carrier == 16383, "R4 carrier falling", carrier, 16383);

    freq = 12'd300;
    wait_sectors(3);
    chk(last_cnt == 2, "R3 strobes per sector at rate 2", last_cnt, 2);
    freq = 12'd100;
    wait_sectors(2);
    // R6: mid-sector request must wait for the boundary
    wait_sectors(1);
    tick(); tick();
    freq = 12'd450;
    tick(); tick(); tick();
    chk(rate == 4, "R6 rate held mid-sector", rate, 4);
    wait_sectors(1);
    chk(rate == 1, "R6 rate applied at boundary", rate, 1);
    wait_sectors(2);
    chk(last_cnt == 1, "R3 strobes per sector at rate 1", last_cnt, 1);
    freq = 12'd100;
    wait_sectors(2);

    chk(off_bnd == 0, "R6 rate changes off boundary", off_bnd, 0);
    chk(step_bad == 0, "R2 bad sector steps", step_bad, 0);
    chk(wraps > 0, "R2 wrap 11->0 observed", wraps, 1);
    chk(cnt_bad == 0, "R3 sectors with wrong strobe count", cnt_bad, 0);
    chk(trough_bad == 0, "R4 nonzero carrier on strobe", trough_bad, 0);

    mod_a = 12'd0; mod_b = 12'd1097; mod_c = 12'd2999;
    wait_sectors(2);
    observe(16);
    chk(seen_a == 4'b0001, "R7 m=0 level set", seen_a, 1);
    chk(seen_b == 4'b0010, "R7 m=1097 level set", seen_b, 2);
    chk(seen_c == 4'b0100, "R7 m=2999 level set", seen_c, 4);

    mod_a = 12'd2048; mod_b = 12'd4095; mod_c = 12'd548;
    wait_sectors(2);
    observe(16);
    chk(seen_a == 4'b0110, "R7 m=2048 level set", seen_a, 6);
    chk(seen_b == 4'b1100, "R7 m=4095 level set", seen_b, 12);
    chk(seen_c == 4'b0011, "R7 m=548 level set", seen_c, 3);

    begin
      logic [1:0] la; logic [14:0] ca;
      step = 16'd0;
      tick(); tick();
      la = lvl_a; ca = carrier;
      mod_a = 12'd0;
      repeat (6) tick();
      chk(lvl_a == la, "R8 level unchanged with step=0", lvl_a, la);
      chk(carrier == ca, "R8 carrier frozen with step=0", carrier, ca);
      step = 16'd4096;
      wait_sectors(2);
      observe(16);
      chk(seen_a == 4'b0001, "R8 new value taken after restart", seen_a, 1);
    end

    summary();
    $finish;
  end
endmodule